// File: doc/BRIEF.md
# Clock Distribution Divider Network

This block is the digital distribution stage that follows a phase-locked oscillator. It takes the oscillator clock as its own clock and derives a family of related clock outputs from it. The first stage is a double-rate output. A system stage runs at half the double rate and drives a bank of identical in-phase outputs and one inverted output. A half-rate stage runs at half the system rate. All three stages form one toggle chain, so every derived output rises on the same edge as the stage that feeds it. A prescale select lets the oscillator clock be used directly or divided by two before it enters the chain.

Two reference inputs feed a selector. The selected reference passes through a synchronizer, and a falling-edge detector follows it. A bypass (test) mode replaces the oscillator path with the synchronized reference. In that mode the double-rate output follows the inverse of the reference, and the system stage advances on each falling reference edge. An active-low enable/reset input puts every clock output into the high-impedance state, which is shown as a per-output enable. It also clears the chain. After it is released, the divided outputs stay low until the first falling edge of the selected reference is seen. The lock output passes an external lock status, and it is forced low in bypass mode.

Top module: `clkdist_net`

## Requirements
- R1: All `sys_q` bits are equal in every cycle. `inv_q` is never high while `sys_q` is high, and it is the inverse of `sys_q` from the first advance of the system stage after release onward. It is low before that advance.
- R2: In oscillator mode, `dbl_q` changes state at each prescaled tick, `sys_q` toggles on every rising edge of `dbl_q` and `half_q` toggles on every rising edge of `sys_q`, so a rise of `half_q` coincides with a rise of `sys_q` and a rise of `sys_q` with a rise of `dbl_q`.
- R3: With `pll_en`=1 and the chain running, `freq_div2`=0 makes `dbl_q` change on every clock. `freq_div2`=1 makes it change on every second clock, and the first change comes two clocks after the chain starts.
- R4: With `pll_en`=0, `dbl_q` equals the inverse of the selected reference with a latency of three clocks: two synchronizer flops plus the output register. `sys_q` toggles exactly in the cycle in which `dbl_q` rises because of a falling reference edge.
- R5: `ref_sel`=0 selects `ref_a` and `ref_sel`=1 selects `ref_b`. The unselected reference has no effect on any output.
- R6: While `oe_rst_n`=0, every clock output enable (`dbl_oe`, `sys_oe`, `inv_oe`, `half_oe`) is 0 in the same cycle and `lock_q` still follows R8. The chain state is cleared to 0 at the next clock edge.
- R7: After `oe_rst_n` rises, in either mode, `sys_q`, `inv_q` and `half_q` stay 0 and `dbl_q` follows the inverse of the selected reference (as in R4) until a falling reference edge is detected. In oscillator mode the chain starts on the clock after that edge.
- R8: `lock_q` equals `lock_in` AND `pll_en` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; all state is clocked on its rising edge |
| oe_rst_n | input | 1 | Active-low output enable and chain reset |
| pll_en | input | 1 | 1 = oscillator drives the chain, 0 = bypass with reference |
| freq_div2 | input | 1 | 1 = oscillator divided by two before the chain |
| ref_a | input | 1 | Reference input A |
| ref_b | input | 1 | Reference input B |
| ref_sel | input | 1 | 0 = reference A, 1 = reference B |
| lock_in | input | 1 | External lock status |
| dbl_q | output | 1 | Double-rate clock data |
| dbl_oe | output | 1 | Enable for dbl_q |
| sys_q | output | NUM_SYS | In-phase system clock data |
| sys_oe | output | NUM_SYS | Enables for sys_q |
| inv_q | output | 1 | Inverted system clock data |
| inv_oe | output | 1 | Enable for inv_q |
| half_q | output | 1 | Half-rate clock data |
| half_oe | output | 1 | Enable for half_q |
| lock_q | output | 1 | Gated lock flag |

## Verification
The chain is run in oscillator mode with the prescaler both off and on, which separates a tick on every clock from a tick on every other clock. It is then run in bypass mode with the two references toggling at different periods. This shows that only the selected one sets the output rate and the falling-edge instants. A release from reset with the selected reference held high, and only later toggling, shows the hold on the divided outputs in bypass mode. An earlier release in oscillator mode shows the hold and the delayed start there. Toggling the lock status in both modes separates the pass-through from the forced-low case.

// File: rtl/clkdist_pkg.sv
package clkdist_pkg;
  localparam logic REF_PICK_B = 1'b1;

  // prescaled tick: every clock when undivided, every second clock when divided
  function automatic logic f_tick(input logic div2, input logic phase);
    return !div2 || phase;
  endfunction

  // falling edge seen between an older and a newer synchronized sample
  function automatic logic f_fall(input logic older, input logic newer);
    return older && !newer;
  endfunction
endpackage

// File: rtl/cd_ref_sync.sv
module cd_ref_sync
  import clkdist_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_a,
  input  logic ref_b,
  input  logic ref_sel,
  output logic ref_s,
  output logic fall
);
  localparam int CHAIN = SYNC_DEPTH + 1;

  logic             ref_pick;
  logic [CHAIN-1:0] pipe;

  assign ref_pick = (ref_sel == REF_PICK_B) ? ref_b : ref_a;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[CHAIN-2:0], ref_pick};
  end

  assign ref_s = pipe[SYNC_DEPTH-1];
  assign fall  = f_fall(pipe[SYNC_DEPTH], pipe[SYNC_DEPTH-1]);
endmodule

// File: rtl/cd_prescale.sv
module cd_prescale
  import clkdist_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic div2,
  output logic tick
);
  logic phase;

  always_ff @(posedge clk) begin
    if (!rst_n)   phase <= 1'b0;
    else if (run) phase <= ~phase;
    else          phase <= 1'b0;
  end

  assign tick = run && f_tick(div2, phase);
endmodule

// File: rtl/cd_toggle_chain.sv
module cd_toggle_chain (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_en,
  input  logic ref_s,
  input  logic fall,
  input  logic tick,
  output logic hold,
  output logic dbl,
  output logic sys,
  output logic inv,
  output logic half
);
  logic track_ref;
  logic release_evt;
  logic adv;

  assign track_ref   = !pll_en || hold;
  assign release_evt = fall && track_ref;
  assign adv         = pll_en ? (!hold && tick && !dbl) : fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= 1'b1;
      dbl  <= 1'b0;
      sys  <= 1'b0;
      inv  <= 1'b0;
      half <= 1'b0;
    end else begin
      if (track_ref) dbl <= ~ref_s;
      else if (tick) dbl <= ~dbl;
      if (release_evt) hold <= 1'b0;
      if (adv) begin
        sys <= ~sys;
        inv <= sys;
        if (!sys) half <= ~half;
      end
    end
  end
endmodule

// File: rtl/clkdist_net.sv
module clkdist_net #(
  parameter int NUM_SYS    = 5,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               clk,
  input  logic               oe_rst_n,
  input  logic               pll_en,
  input  logic               freq_div2,
  input  logic               ref_a,
  input  logic               ref_b,
  input  logic               ref_sel,
  input  logic               lock_in,
  output logic               dbl_q,
  output logic               dbl_oe,
  output logic [NUM_SYS-1:0] sys_q,
  output logic [NUM_SYS-1:0] sys_oe,
  output logic               inv_q,
  output logic               inv_oe,
  output logic               half_q,
  output logic               half_oe,
  output logic               lock_q
);
  logic ref_s_w;
  logic fall_w;
  logic hold_w;
  logic tick_w;
  logic sys_w;

  cd_ref_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(oe_rst_n), .ref_a(ref_a), .ref_b(ref_b),
    .ref_sel(ref_sel), .ref_s(ref_s_w), .fall(fall_w)
  );

  cd_prescale u_pre (
    .clk(clk), .rst_n(oe_rst_n), .run(pll_en && !hold_w),
    .div2(freq_div2), .tick(tick_w)
  );

  cd_toggle_chain u_chain (
    .clk(clk), .rst_n(oe_rst_n), .pll_en(pll_en), .ref_s(ref_s_w),
    .fall(fall_w), .tick(tick_w), .hold(hold_w), .dbl(dbl_q),
    .sys(sys_w), .inv(inv_q), .half(half_q)
  );

  for (genvar i = 0; i < NUM_SYS; i++) begin : g_sys
    assign sys_q[i]  = sys_w;
    assign sys_oe[i] = oe_rst_n;
  end

  assign dbl_oe  = oe_rst_n;
  assign inv_oe  = oe_rst_n;
  assign half_oe = oe_rst_n;
  assign lock_q  = lock_in && pll_en;
endmodule

// File: rtl/clkdist_net_chk.sv
module clkdist_net_chk #(
  parameter int NUM_SYS = 5
) (
  input logic               clk,
  input logic               oe_rst_n,
  input logic               pll_en,
  input logic               freq_div2,
  input logic               hold_w,
  input logic               fall_w,
  input logic               dbl_q,
  input logic               dbl_oe,
  input logic [NUM_SYS-1:0] sys_q,
  input logic [NUM_SYS-1:0] sys_oe,
  input logic               inv_q,
  input logic               inv_oe,
  input logic               half_q,
  input logic               half_oe,
  input logic               lock_q
);
  AST_SYS_UNIFORM: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ($countones(sys_q) == 0) || ($countones(sys_q) == NUM_SYS)); // R1

  AST_INV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!oe_rst_n)
    !(inv_q && sys_q[0])); // R1

  AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!oe_rst_n)
    $rose(half_q) |-> $rose(sys_q[0])); // R2

  AST_SYS_ALIGN: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ($rose(sys_q[0]) && $past(oe_rst_n) && $past(oe_rst_n, 2) &&
     ($past(pll_en) == $past(pll_en, 2))) |-> $rose(dbl_q)); // R2

  AST_DIV2_SPACING: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ($past(oe_rst_n) && $past(pll_en && freq_div2 && !hold_w) &&
     pll_en && freq_div2 && !hold_w && !$stable(dbl_q)) |=> $stable(dbl_q)); // R3

  AST_BYPASS_ON_FALL: assert property (@(posedge clk) disable iff (!oe_rst_n)
    ($past(!pll_en) && $past(oe_rst_n) && !$stable(sys_q[0])) |-> $past(fall_w)); // R4

  AST_OUTPUTS_OFF: assert property (@(posedge clk)
    !oe_rst_n |-> (!dbl_oe && (sys_oe == '0) && !inv_oe && !half_oe)); // R6

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!oe_rst_n)
    hold_w |-> (!sys_q[0] && !inv_q && !half_q)); // R7

  AST_LOCK_GATED: assert property (@(posedge clk)
    !pll_en |-> !lock_q); // R8
endmodule

bind clkdist_net clkdist_net_chk #(.NUM_SYS(NUM_SYS)) u_chk (
  .clk(clk), .oe_rst_n(oe_rst_n), .pll_en(pll_en), .freq_div2(freq_div2),
  .hold_w(hold_w), .fall_w(fall_w), .dbl_q(dbl_q), .dbl_oe(dbl_oe),
  .sys_q(sys_q), .sys_oe(sys_oe), .inv_q(inv_q), .inv_oe(inv_oe),
  .half_q(half_q), .half_oe(half_oe), .lock_q(lock_q)
);

// File: tb/tb_clkdist_net.sv
`timescale 1ns/1ps
module tb_clkdist_net;
  localparam int NSYS = 5;

  logic clk = 1'b0;
  logic oe_rst_n, pll_en, freq_div2, ref_a, ref_b, ref_sel, lock_in;
  logic dbl_q, dbl_oe, inv_q, inv_oe, half_q, half_oe, lock_q;
  logic [NSYS-1:0] sys_q, sys_oe;

  clkdist_net #(.NUM_SYS(NSYS), .SYNC_DEPTH(2)) dut (
    .clk(clk), .oe_rst_n(oe_rst_n), .pll_en(pll_en), .freq_div2(freq_div2),
    .ref_a(ref_a), .ref_b(ref_b), .ref_sel(ref_sel), .lock_in(lock_in),
    .dbl_q(dbl_q), .dbl_oe(dbl_oe), .sys_q(sys_q), .sys_oe(sys_oe),
    .inv_q(inv_q), .inv_oe(inv_oe), .half_q(half_q), .half_oe(half_oe),
    .lock_q(lock_q)
  );

  always #10 clk = ~clk; // 50 MHz

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  string phase_tag = "R6";
  bit    done = 0;

  // reference generators
  bit gen_a = 1, gen_b = 1;
  int per_a = 6, per_b = 9, cnt_a = 0, cnt_b = 0;

  // behavioural model state
  bit hist[$] = '{0, 0, 0};  // [0] newest sample ... [2] oldest
  bit m_hold = 1, m_phase = 0, m_dbl = 0, m_sys = 0, m_inv = 0, m_half = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    bit picked, older, newer, step;
    cycles++;
    if (!oe_rst_n) begin
      hist = '{0, 0, 0};
      m_hold = 1; m_phase = 0; m_dbl = 0; m_sys = 0; m_inv = 0; m_half = 0;
    end else begin
      picked = ref_sel ? ref_b : ref_a;
      newer  = hist[1];
      older  = hist[2];
      step   = 0;
      if (!pll_en || m_hold) begin
        m_dbl   = !newer;
        m_phase = 0;
        if (older && !newer) begin
          m_hold = 0;
          if (!pll_en) step = 1;
        end
      end else begin
        if (!freq_div2 || m_phase) begin
          if (!m_dbl) step = 1;
          m_dbl = !m_dbl;
        end
        m_phase = !m_phase;
      end
      if (step) begin
        if (!m_sys) m_half = !m_half;
        m_inv = m_sys;
        m_sys = !m_sys;
      end
      hist.push_front(picked);
      void'(hist.pop_back());
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(phase_tag, "dbl_q", int'(dbl_q), int'(m_dbl));
      chk("R1", "sys_q", int'(sys_q), m_sys ? ((1 << NSYS) - 1) : 0);
      chk("R1", "inv_q", int'(inv_q), int'(m_inv));
      chk("R2", "half_q", int'(half_q), int'(m_half));
      chk("R6", "enables", int'({dbl_oe, sys_oe, inv_oe, half_oe}),
          oe_rst_n ? ((1 << (NSYS + 3)) - 1) : 0);
      chk("R8", "lock_q", int'(lock_q), int'(lock_in && pll_en));
    end
  end

  always @(negedge clk) begin
    #1;
    if (gen_a) begin
      if (cnt_a == per_a - 1) begin ref_a <= ~ref_a; cnt_a <= 0; end
      else cnt_a <= cnt_a + 1;
    end
    if (gen_b) begin
      if (cnt_b == per_b - 1) begin ref_b <= ~ref_b; cnt_b <= 0; end
      else cnt_b <= cnt_b + 1;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic finish_up;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    oe_rst_n = 0; pll_en = 1; freq_div2 = 0; ref_a = 0; ref_b = 0;
    ref_sel = 0; lock_in = 1;
    run(6);                                   // R6 reset state
    chk("R6", "sys_q after reset", int'(sys_q), 0);
    phase_tag = "R7"; oe_rst_n = 1; run(20);  // R7 hold in oscillator mode
    phase_tag = "R3"; run(80);                // R3 undivided
    lock_in = 0; run(10);                     // R8 pass-through low
    chk("R8", "lock_q pass", int'(lock_q), 0);
    lock_in = 1;
    freq_div2 = 1; run(150);                  // R3 divided
    phase_tag = "R4"; pll_en = 0; run(150);   // R4 bypass on ref_a
    chk("R8", "lock_q forced low", int'(lock_q), 0);
    phase_tag = "R5"; ref_sel = 1; run(150);  // R5 bypass on ref_b
    phase_tag = "R2"; pll_en = 1; freq_div2 = 0; run(100);
    phase_tag = "R6"; oe_rst_n = 0; run(3);
    pll_en = 0; gen_b = 0; ref_b = 1;
    phase_tag = "R7"; oe_rst_n = 1; run(40);  // R7 hold in bypass with ref high
    chk("R7", "sys_q held", int'(sys_q), 0);
    chk("R7", "half_q held", int'(half_q), 0);
    gen_b = 1; run(80);
    phase_tag = "R1"; pll_en = 1; run(100);
    finish_up();
  end
endmodule